// File: doc/BRIEF.md
# ADC Capture Write Buffer

This block sits between a free-running two-channel ADC sample stream and the write port of a memory controller's 64-word write FIFO. The source delivers one sample pair per clock and cannot be paused, so while a capture is running every valid pair is packed into one 16-bit word and written on the following cycle. The downstream full flag is registered and arrives one cycle after the write that filled the FIFO. For this reason the block does not rely on it alone. It compares the downstream occupancy count against a threshold placed a parameterised margin below the depth, and blocks writes before the FIFO can fill.

A capture is started by a one-cycle start pulse, which also latches the sample-count limit. It ends when the programmed number of words has been written, or early on a stop pulse. Any valid sample that arrives while writes are blocked is dropped. A dropped sample sets a sticky overrun flag, which stays set until the next accepted start.

The control is a four-state machine. IDLE waits. RUN writes. HOLD means capture is still armed while the margin or the full flag blocks writes. DONE means the length was reached. The transitions are:
- IDLE or DONE to RUN on start with a nonzero length.
- IDLE or DONE to DONE on start with a zero length.
- RUN to HOLD when no room is left.
- HOLD to RUN when room returns.
- RUN or HOLD to DONE when the last word is written.
- RUN or HOLD to IDLE on stop.

Top module: `acw_capture`

## Requirements
- R1: After reset, wr_en, busy, done and overrun are all low.
- R2: While busy with room available, each valid sample pair is written on the next cycle: wr_en is high, wr_data[7:0] carries the smp_a byte and wr_data[15:8] carries the smp_b byte.
- R3: A sample that arrives while fifo_cnt is at or above FIFO_DEPTH - MARGIN (60 by default) is not written.
- R4: A sample that arrives while fifo_full is high is not written, whatever the count.
- R5: A valid sample that arrives while busy and blocked by R3 or R4 sets overrun on the next cycle. overrun then stays high until the next accepted start.
- R6: An accepted start (one that arrives in IDLE or DONE) clears overrun and done and restarts the word count.
- R7: When the write of word number cap_len is issued, done rises and busy falls in the same cycle that this write appears on wr_en. No further writes follow.
- R8: A start with cap_len equal to zero goes straight to done, and no word is written.
- R9: A stop while busy ends the capture. The sample in the stop cycle is not written, busy falls and done stays low.
- R10: A start that arrives while busy is ignored. The length and count in use, and the overrun flag, are unchanged.
- R11: Cycles with smp_valid low neither write, advance the count, nor set overrun.
- R12: Once room returns after a block (HOLD state), valid samples are written again without a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_start | input | 1 | One-cycle capture start; latches cap_len |
| cap_stop | input | 1 | One-cycle capture abort |
| cap_len | input | LEN_W (27) | Number of words to capture |
| smp_valid | input | 1 | Sample pair present this cycle |
| smp_a | input | SMP_W (8) | First channel sample |
| smp_b | input | SMP_W (8) | Second channel sample |
| fifo_cnt | input | CNT_W (7) | Downstream FIFO occupancy |
| fifo_full | input | 1 | Downstream full flag (registered, late) |
| wr_en | output | 1 | Downstream write strobe |
| wr_data | output | 2*SMP_W (16) | Packed sample word |
| busy | output | 1 | Capture armed (RUN or HOLD) |
| done | output | 1 | Programmed length reached |
| overrun | output | 1 | Sticky dropped-sample flag |

## Verification
Two situations can make two functions fall in the same cycle.

The first is the stop pulse arriving together with the sample that would complete the length. The scoreboard expects stop to win: no write, done stays low and busy falls.

The second is the completing sample arriving when fifo_cnt sits exactly at the threshold. The sample must be dropped and overrun raised, and the capture completes only with the next sample written under room.

Both cases are driven as single-cycle coincidences after a partial capture. They are judged against an independent cycle model in the bench.

// File: rtl/acw_pkg.sv
package acw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2,
        ST_DONE = 2'd3
    } acw_state_e;

endpackage

// File: rtl/acw_room.sv
module acw_room #(
    parameter int CNT_W      = 7,
    parameter int FIFO_DEPTH = 64,
    parameter int MARGIN     = 4
) (
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             fifo_full,
    output logic             room
);

    localparam int              THRESH_I = FIFO_DEPTH - MARGIN;
    localparam logic [CNT_W-1:0] THRESH  = CNT_W'(THRESH_I);

    // Room exists only below the threshold and with no late full flag.
    always_comb begin
        room = !fifo_full && (fifo_cnt < THRESH);
    end

    // R3
    initial margin_cover_chk: assert (MARGIN >= 2 && MARGIN < FIFO_DEPTH);

endmodule

// File: rtl/acw_count.sv
module acw_count #(
    parameter int LEN_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] len_in,
    output logic             last_w,
    output logic             len_zero
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            len_q <= len_in;
        end else if (inc) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    always_comb begin
        last_w   = (cnt_q + LEN_W'(1)) == len_q;
        len_zero = (len_in == '0);
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= len_q);

endmodule

// File: rtl/acw_fsm.sv
module acw_fsm
    import acw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       valid,
    input  logic       room,
    input  logic       last_w,
    input  logic       len_zero,
    output logic       fire,
    output logic       clr,
    output logic       ovr_set,
    output acw_state_e state_o
);

    acw_state_e state_q;
    acw_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        clr     = 1'b0;
        ovr_set = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    clr     = 1'b1;
                    state_d = len_zero ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN, ST_HOLD: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end else begin
                    fire    = valid && room;
                    ovr_set = valid && !room;
                    if (fire && last_w) state_d = ST_DONE;
                    else                state_d = room ? ST_RUN : ST_HOLD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

    // R12
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !$past(room));

endmodule

// File: rtl/acw_pack.sv
module acw_pack #(
    parameter int SMP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [SMP_W-1:0]   smp_a,
    input  logic [SMP_W-1:0]   smp_b,
    output logic               wr_en,
    output logic [2*SMP_W-1:0] wr_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= fire;
            if (fire) wr_data <= {smp_b, smp_a};
        end
    end

endmodule

// File: rtl/acw_capture.sv
module acw_capture
    import acw_pkg::*;
#(
    parameter int SMP_W      = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int MARGIN     = 4,
    parameter int LEN_W      = 27,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int WORD_W    = 2 * SMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_start,
    input  logic              cap_stop,
    input  logic [LEN_W-1:0]  cap_len,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_a,
    input  logic [SMP_W-1:0]  smp_b,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              overrun
);

    logic       room;
    logic       last_w;
    logic       len_zero;
    logic       fire;
    logic       clr;
    logic       ovr_set;
    acw_state_e state;
    logic       ovr_q;

    acw_room #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .MARGIN(MARGIN)) u_room (
        .fifo_cnt (fifo_cnt),
        .fifo_full(fifo_full),
        .room     (room)
    );

    acw_count #(.LEN_W(LEN_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .inc     (fire),
        .len_in  (cap_len),
        .last_w  (last_w),
        .len_zero(len_zero)
    );

    acw_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cap_start),
        .stop    (cap_stop),
        .valid   (smp_valid),
        .room    (room),
        .last_w  (last_w),
        .len_zero(len_zero),
        .fire    (fire),
        .clr     (clr),
        .ovr_set (ovr_set),
        .state_o (state)
    );

    acw_pack #(.SMP_W(SMP_W)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .smp_a  (smp_a),
        .smp_b  (smp_b),
        .wr_en  (wr_en),
        .wr_data(wr_data)
    );

    // Sticky dropped-sample flag; an accepted start clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (clr)     ovr_q <= 1'b0;
        else if (ovr_set) ovr_q <= 1'b1;
    end

    always_comb begin
        busy    = (state == ST_RUN) || (state == ST_HOLD);
        done    = (state == ST_DONE);
        overrun = ovr_q;
    end

    // R4
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> !wr_en);

    // R3
    no_write_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt >= CNT_W'(FIFO_DEPTH - MARGIN)) |=> !wr_en);

    // R5
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !cap_start) |=> overrun);

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cap_stop && smp_valid && fifo_full) |=> overrun);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || !smp_valid) |=> !wr_en);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_start) |=> (!wr_en && done));

endmodule

// File: tb/acw_capture_tb.sv
module acw_capture_tb;

    localparam int LEN_W = 27;
    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cap_start = 1'b0;
    logic             cap_stop = 1'b0;
    logic [LEN_W-1:0] cap_len = '0;
    logic             smp_valid = 1'b0;
    logic [7:0]       smp_a = '0;
    logic [7:0]       smp_b = '0;
    logic [CNT_W-1:0] fifo_cnt = '0;
    logic             fifo_full = 1'b0;
    logic             wr_en;
    logic [15:0]      wr_data;
    logic             busy;
    logic             done;
    logic             overrun;

    always #5 clk = ~clk;

    acw_capture u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_start(cap_start),
        .cap_stop (cap_stop),
        .cap_len  (cap_len),
        .smp_valid(smp_valid),
        .smp_a    (smp_a),
        .smp_b    (smp_b),
        .fifo_cnt (fifo_cnt),
        .fifo_full(fifo_full),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .busy     (busy),
        .done     (done),
        .overrun  (overrun)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] d;
        logic        bz;
        logic        dn;
        logic        ov;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_vec = 0;
    int    n_err = 0;
    bit    finished = 1'b0;

    // Reference model state.
    bit m_active = 0;
    bit m_done   = 0;
    bit m_ovr    = 0;
    int m_len    = 0;
    int m_cnt    = 0;

    task automatic check1(string tag, string what, logic act, logic expv);
        n_vec++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(bit st, bit sp, int len, bit v, logic [7:0] a, logic [7:0] b,
                        int cnt, bit full, string tag);
        exp_t e;
        bit room;
        @(negedge clk);
        cap_start = st; cap_stop = sp; cap_len = LEN_W'(len);
        smp_valid = v; smp_a = a; smp_b = b;
        fifo_cnt = CNT_W'(cnt); fifo_full = full;
        room = !full && (cnt < 60);
        e = '0;
        if (m_active) begin
            if (sp) begin
                m_active = 0;
            end else if (v) begin
                if (room) begin
                    e.we = 1; e.d = {b, a};
                    m_cnt++;
                    if (m_cnt == m_len) begin m_active = 0; m_done = 1; end
                end else begin
                    m_ovr = 1;
                end
            end
        end else if (st) begin
            m_ovr = 0; m_cnt = 0; m_len = len;
            if (len == 0) m_done = 1;
            else begin m_active = 1; m_done = 0; end
        end
        e.bz = m_active; e.dn = m_done; e.ov = m_ovr;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00, 8'h00, 0, 0, tag);
    endtask

    // Monitor: compare each result after the edge that produces it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check1(t, "wr_en", wr_en, e.we);
                if (e.we) begin
                    n_vec++;
                    if (wr_data !== e.d) begin
                        n_err++;
                        $display("FAIL %s wr_data actual=%h expected=%h", t, wr_data, e.d);
                    end
                end
                check1(t, "busy", busy, e.bz);
                check1(t, "done", done, e.dn);
                check1(t, "overrun", overrun, e.ov);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check1("R1", "wr_en", wr_en, 1'b0);
        check1("R1", "busy", busy, 1'b0);
        check1("R1", "done", done, 1'b0);
        check1("R1", "overrun", overrun, 1'b0);

        // R2 / R7: length 5, six samples offered, the sixth is not written
        step(1, 0, 5, 0, 8'h00, 8'h00, 0, 0, "R6");
        for (int i = 0; i < 6; i++)
            step(0, 0, 0, 1, 8'(8'h11 * i + 1), 8'(8'hA0 ^ i), i * 7, 0, "R2_R7");
        idle(2, "R7");

        // R11: gaps in valid do not count
        step(1, 0, 3, 0, 8'h00, 8'h00, 0, 0, "R6");
        step(0, 0, 0, 1, 8'h3C, 8'hC3, 2, 0, "R11");
        step(0, 0, 0, 0, 8'hFF, 8'hFF, 2, 0, "R11");
        step(0, 0, 0, 0, 8'hEE, 8'hEE, 63, 1, "R11");
        step(0, 0, 0, 1, 8'h01, 8'h80, 3, 0, "R11");
        step(0, 0, 0, 0, 8'h55, 8'h55, 3, 0, "R11");
        step(0, 0, 0, 1, 8'h7E, 8'hE7, 4, 0, "R11");
        idle(1, "R11");

        // R3 / R4 / R5 / R12 / R9: margin, full, resume, stop
        step(1, 0, 100, 0, 8'h00, 8'h00, 0, 0, "R6");
        step(0, 0, 0, 1, 8'h10, 8'h20, 59, 0, "R3");
        step(0, 0, 0, 1, 8'h11, 8'h21, 60, 0, "R3_R5");
        step(0, 0, 0, 1, 8'h12, 8'h22, 63, 0, "R3_R5");
        step(0, 0, 0, 1, 8'h13, 8'h23, 10, 0, "R12");
        step(0, 0, 0, 1, 8'h14, 8'h24, 0, 1, "R4");
        step(0, 0, 0, 1, 8'h15, 8'h25, 5, 0, "R12");
        step(0, 1, 0, 1, 8'h16, 8'h26, 5, 0, "R9");
        step(0, 0, 0, 1, 8'h17, 8'h27, 5, 0, "R9_R5");
        idle(2, "R5");

        // R6 / R10: restart clears overrun; start while busy ignored
        step(1, 0, 4, 0, 8'h00, 8'h00, 0, 0, "R6");
        step(0, 0, 0, 1, 8'hA1, 8'hB1, 1, 0, "R10");
        step(0, 0, 0, 1, 8'hA2, 8'hB2, 2, 0, "R10");
        step(1, 0, 50, 1, 8'hA3, 8'hB3, 3, 0, "R10");
        step(0, 0, 0, 1, 8'hA4, 8'hB4, 4, 0, "R10_R7");
        step(0, 0, 0, 1, 8'hA5, 8'hB5, 4, 0, "R7");
        idle(1, "R7");

        // R8: zero length
        step(1, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R8");
        step(0, 0, 0, 1, 8'h99, 8'h66, 0, 0, "R8");
        step(0, 0, 0, 1, 8'h98, 8'h67, 0, 0, "R8");

        // Coincidence: stop with the completing sample
        step(1, 0, 2, 0, 8'h00, 8'h00, 0, 0, "R6");
        step(0, 0, 0, 1, 8'hC1, 8'hD1, 0, 0, "R2");
        step(0, 1, 0, 1, 8'hC2, 8'hD2, 0, 0, "R9");
        idle(2, "R9");

        // Coincidence: completing sample at the threshold
        step(1, 0, 2, 0, 8'h00, 8'h00, 0, 0, "R6");
        step(0, 0, 0, 1, 8'hE1, 8'hF1, 0, 0, "R2");
        step(0, 0, 0, 1, 8'hE2, 8'hF2, 60, 0, "R3_R5");
        step(0, 0, 0, 1, 8'hE3, 8'hF3, 1, 0, "R12_R7");
        idle(3, "R7");

        @(posedge clk);
        #3;
        finish_run();
    end

endmodule